// File: doc/BRIEF.md
# Dual-Mode Programmable Frequency Divider

This block divides a local-oscillator tick stream by a programmable integer and emits one single-cycle pulse per completed division, which a phase comparator uses as its feedback edge. All inputs are synchronous to one system clock. Each oscillator edge arrives as a one-cycle tick on one of two inputs: a high-band input and a low-band input.

Two division schemes share one divisor register. In pulse-swallow division, the selected ticks are routed to an external 16/17 dual-modulus prescaler. The block then counts the prescaler's output ticks with a 4-bit swallow counter and a 12-bit main counter, and it drives the prescaler's modulus-select line. In direct division, low-band ticks are counted by a 12-bit down-counter and the prescaler is not used.

A controller presents a divisor word and two mode bits with a one-cycle load strobe. The block clamps an out-of-range word to the floor of its mode and records the event in a sticky flag. The new settings are held as pending and take effect at the end of the divide cycle in progress.

Top module: `dmod_divider`

## Requirements
- R1: After reset, div_pulse, mod_hi, psc_src and range_err are 0, and the block divides low-band ticks directly by 4.
- R2: With band_sel=0 and swallow_sel=0 (direct mode), div_pulse fires once every N low-band ticks. N is div_word[11:0] and ranges from 4 to 4095. Bits 15:12 of the word have no effect.
- R3: With band_sel=0 and swallow_sel=1, div_pulse fires once every N low-band ticks. N is the full 16-bit div_word and ranges from 272 to 65535. High-band ticks have no effect.
- R4: With band_sel=1, the block always uses pulse-swallow division of high-band ticks, whatever the value of swallow_sel.
- R5: In pulse-swallow mode, psc_src carries the selected ticks to the prescaler. The prescaler divides by 17 while mod_hi=1 and by 16 while mod_hi=0. Each divide cycle spans div_word[15:4] prescaler outputs, and the first div_word[3:0] of them are divide-by-17 cycles.
- R6: In direct mode, mod_hi and psc_src stay at 0.
- R7: A word below the floor of the requested mode is replaced by that floor and sets range_err. The floor is 272 for pulse-swallow mode and 4 for direct mode, where the floor is compared against bits 11:0.
- R8: range_err stays at 1 until reset. A load within range never sets it.
- R9: A load does not change the divide cycle in progress. The new divisor and mode apply from the next div_pulse onward.
- R10: div_pulse is high for exactly one clock cycle per divide cycle.
- R11: When several loads arrive within one divide cycle, the last one is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_tick | input | 1 | High-band oscillator tick |
| lb_tick | input | 1 | Low-band oscillator tick |
| load | input | 1 | One-cycle strobe that captures the word and the mode bits |
| band_sel | input | 1 | 1 selects the high-band input |
| swallow_sel | input | 1 | 1 selects pulse-swallow division on the low band |
| div_word | input | 16 | Divisor word |
| psc_tick | input | 1 | Output tick of the external prescaler |
| psc_src | output | 1 | Tick stream routed to the prescaler |
| mod_hi | output | 1 | Prescaler modulus select: 1 for /17, 0 for /16 |
| div_pulse | output | 1 | One-cycle pulse at each terminal count |
| range_err | output | 1 | Sticky flag for a clamped divisor |

## Verification
A wrong counter load or a wrong decrement shows up as a wrong spacing between div_pulse edges, and it shows within the first full divide cycle after the settings are applied. A wrong swallow count shows in the number of divide-by-17 prescaler cycles between two pulses. That count is visible only through mod_hi, so a mismatch appears within one divide cycle even when the total period happens to come out right. Errors in pending-versus-active handling appear in the period that straddles a load: it must keep the old length. Mode-select errors show as activity on psc_src or mod_hi during direct division, or as a period scaled by the wrong input's tick rate.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int FD_DIV_W = 16;
  typedef logic [FD_DIV_W-1:0] fd_word_t;
  typedef struct packed {
    logic     hb;
    logic     sw;
    fd_word_t div;
  } fd_cfg_t;
endpackage

// File: rtl/fdiv_load.sv
module fdiv_load
  import fdiv_pkg::*;
#(
  parameter int SW_MIN  = 272,
  parameter int DIR_W   = 12,
  parameter int DIR_MIN = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  logic     band_in,
  input  logic     sw_in,
  input  fd_word_t word_in,
  input  logic     apply,
  output logic     act_hb,
  output logic     act_sw,
  output fd_word_t nxt_div,
  output logic     range_err
);
  localparam fd_word_t SW_FLOOR = fd_word_t'(SW_MIN);
  localparam logic [DIR_W-1:0] DIR_FLOOR = DIR_W'(DIR_MIN);
  localparam fd_cfg_t RST_CFG = '{hb: 1'b0, sw: 1'b0, div: fd_word_t'(DIR_MIN)};

  fd_cfg_t          act_cfg;
  fd_cfg_t          pend_cfg;
  logic             pend_v;
  logic             req_sw;
  logic             bad;
  logic [DIR_W-1:0] low;
  fd_word_t         clamped;

  // Clamp the requested word against the floor of the requested mode.
  always_comb begin
    req_sw = band_in | sw_in;
    low    = word_in[DIR_W-1:0];
    if (req_sw) begin
      bad     = (word_in < SW_FLOOR);
      clamped = bad ? SW_FLOOR : word_in;
    end else begin
      bad     = (low < DIR_FLOOR);
      clamped = bad ? fd_word_t'(DIR_FLOOR) : fd_word_t'(low);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_cfg   <= RST_CFG;
      pend_cfg  <= '0;
      pend_v    <= 1'b0;
      range_err <= 1'b0;
    end else begin
      if (apply) begin
        act_cfg <= pend_v ? pend_cfg : act_cfg;
        pend_v  <= 1'b0;
      end
      if (load) begin
        pend_cfg <= '{hb: band_in, sw: req_sw, div: clamped};
        pend_v   <= 1'b1;
        if (bad) range_err <= 1'b1;
      end
    end
  end

  assign act_hb  = act_cfg.hb;
  assign act_sw  = act_cfg.sw;
  assign nxt_div = pend_v ? pend_cfg.div : act_cfg.div;

  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (rst) !apply |=> $stable(act_cfg)) else $error("config changed off boundary"); // R9
  AST_SW_FLOOR: assert property (@(posedge clk) disable iff (rst) act_cfg.sw |-> (act_cfg.div >= SW_FLOOR)) else $error("swallow divisor below floor"); // R7
  AST_DIR_FLOOR: assert property (@(posedge clk) disable iff (rst) !act_cfg.sw |-> (act_cfg.div[DIR_W-1:0] >= DIR_FLOOR)) else $error("direct divisor below floor"); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) range_err |=> range_err) else $error("range flag cleared"); // R8
  AST_HB_SWALLOW: assert property (@(posedge clk) disable iff (rst) act_cfg.hb |-> act_cfg.sw) else $error("high band not in swallow mode"); // R4
endmodule

// File: rtl/fdiv_swallow.sv
module fdiv_swallow
  import fdiv_pkg::*;
#(
  parameter int SW_BITS = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     step,
  input  logic     reload,
  input  fd_word_t ld_div,
  output logic     term,
  output logic     mod_hi
);
  localparam int MAIN_W = FD_DIV_W - SW_BITS;

  logic [SW_BITS-1:0] swc;
  logic [MAIN_W-1:0]  mcnt;

  assign term   = en && step && (mcnt == MAIN_W'(1));
  assign mod_hi = en && (swc != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      swc  <= '0;
      mcnt <= '0;
    end else if (reload) begin
      swc  <= ld_div[SW_BITS-1:0];
      mcnt <= ld_div[FD_DIV_W-1:SW_BITS];
    end else if (en && step) begin
      mcnt <= mcnt - MAIN_W'(1);
      if (swc != '0) swc <= swc - SW_BITS'(1);
    end
  end

  AST_MAIN_ABOVE_SWC: assert property (@(posedge clk) disable iff (rst) en |-> (mcnt > MAIN_W'(swc))) else $error("swallow count reached main count"); // R5
endmodule

// File: rtl/fdiv_direct.sv
module fdiv_direct #(
  parameter int DIR_W   = 12,
  parameter int DIR_MIN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             step,
  input  logic             reload,
  input  logic [DIR_W-1:0] ld_div,
  output logic             term
);
  logic [DIR_W-1:0] cnt;

  assign term = en && step && (cnt == DIR_W'(1));

  always_ff @(posedge clk) begin
    if (rst)              cnt <= DIR_W'(DIR_MIN);
    else if (reload)      cnt <= ld_div;
    else if (en && step)  cnt <= cnt - DIR_W'(1);
  end

  AST_DCNT_LIVE: assert property (@(posedge clk) disable iff (rst) en |-> (cnt != '0)) else $error("direct counter underflow"); // R2
endmodule

// File: rtl/dmod_divider.sv
module dmod_divider
  import fdiv_pkg::*;
#(
  parameter int SW_BITS = 4,
  parameter int SW_MIN  = 272,
  parameter int DIR_W   = 12,
  parameter int DIR_MIN = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hb_tick,
  input  logic                lb_tick,
  input  logic                load,
  input  logic                band_sel,
  input  logic                swallow_sel,
  input  logic [FD_DIV_W-1:0] div_word,
  input  logic                psc_tick,
  output logic                psc_src,
  output logic                mod_hi,
  output logic                div_pulse,
  output logic                range_err
);
  logic     act_hb;
  logic     act_sw;
  fd_word_t nxt_div;
  logic     sw_term;
  logic     dir_term;
  logic     apply;
  logic     sel_tick;

  assign apply    = sw_term | dir_term;
  assign sel_tick = act_hb ? hb_tick : lb_tick;

  fdiv_load #(.SW_MIN(SW_MIN), .DIR_W(DIR_W), .DIR_MIN(DIR_MIN)) load_i (
    .clk(clk), .rst(rst), .load(load), .band_in(band_sel), .sw_in(swallow_sel),
    .word_in(div_word), .apply(apply), .act_hb(act_hb), .act_sw(act_sw),
    .nxt_div(nxt_div), .range_err(range_err)
  );

  fdiv_swallow #(.SW_BITS(SW_BITS)) swallow_i (
    .clk(clk), .rst(rst), .en(act_sw), .step(psc_tick), .reload(apply),
    .ld_div(nxt_div), .term(sw_term), .mod_hi(mod_hi)
  );

  fdiv_direct #(.DIR_W(DIR_W), .DIR_MIN(DIR_MIN)) direct_i (
    .clk(clk), .rst(rst), .en(!act_sw), .step(lb_tick), .reload(apply),
    .ld_div(nxt_div[DIR_W-1:0]), .term(dir_term)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_src   <= 1'b0;
      div_pulse <= 1'b0;
    end else begin
      psc_src   <= act_sw && sel_tick;
      div_pulse <= apply;
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst) div_pulse |=> !div_pulse) else $error("pulse wider than one cycle"); // R10
  AST_DIRECT_QUIET: assert property (@(posedge clk) disable iff (rst) (!act_sw && !$past(act_sw)) |-> (!psc_src && !mod_hi)) else $error("prescaler driven in direct mode"); // R6
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst) div_pulse |-> $past(psc_tick || lb_tick)) else $error("pulse without a counted tick"); // R3
endmodule

// File: tb/dmod_divider_tb_top.sv
module dmod_divider_tb_top;
  import fdiv_pkg::*;

  localparam int LG = 2;
  localparam int HG = 3;

  logic clk = 1'b0;
  logic rst, hb_tick, lb_tick, load, band_sel, swallow_sel, psc_tick;
  logic [15:0] div_word;
  logic psc_src, mod_hi, div_pulse, range_err;
  logic last17;
  int checks = 0;
  int errors = 0;
  int dbl = 0;
  int cur_n = 4;
  int cur_g = LG;

  always #5 clk = ~clk;

  dmod_divider dut_i (
    .clk(clk), .rst(rst), .hb_tick(hb_tick), .lb_tick(lb_tick), .load(load),
    .band_sel(band_sel), .swallow_sel(swallow_sel), .div_word(div_word),
    .psc_tick(psc_tick), .psc_src(psc_src), .mod_hi(mod_hi),
    .div_pulse(div_pulse), .range_err(range_err)
  );

  // Oscillator tick sources with different rates.
  initial begin
    int lc = 0;
    int hc = 0;
    lb_tick = 1'b0;
    hb_tick = 1'b0;
    forever begin
      @(negedge clk);
      lb_tick = (lc == 0);
      hb_tick = (hc == 0);
      lc = (lc + 1) % LG;
      hc = (hc + 1) % HG;
    end
  end

  // Dual-modulus 16/17 prescaler model.
  initial begin
    int pcnt = 0;
    psc_tick = 1'b0;
    last17 = 1'b0;
    forever begin
      @(posedge clk);
      if (rst) begin
        pcnt = 0;
        psc_tick <= 1'b0;
      end else begin
        psc_tick <= 1'b0;
        if (psc_src) begin
          if (pcnt + 1 == (mod_hi ? 17 : 16)) begin
            pcnt = 0;
            psc_tick <= 1'b1;
            last17 <= mod_hi;
          end else begin
            pcnt = pcnt + 1;
          end
        end
      end
    end
  end

  initial begin
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      if (div_pulse && prev) dbl++;
      prev = div_pulse;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_n(input bit b, input bit s, input int w);
    int low;
    if (b || s) return (w < 272) ? 272 : w;
    low = w & 4095;
    return (low < 4) ? 4 : low;
  endfunction

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  // Measures one divide cycle starting at the negedge that shows a pulse.
  task automatic run_period(input bit ld, input bit ld2, input bit b, input bit s,
                            input int w, input int w2,
                            output int cyc, output int npsc, output int n17, output int nq);
    cyc = 0; npsc = 0; n17 = 0; nq = 0;
    if (ld) begin
      load = 1'b1; band_sel = b; swallow_sel = s; div_word = w[15:0];
    end
    do begin
      @(negedge clk);
      if (ld2 && cyc == 0) begin
        load = 1'b1; div_word = w2[15:0];
      end else begin
        load = 1'b0;
      end
      cyc++;
      if (psc_tick) begin
        npsc++;
        if (last17) n17++;
      end
      if (mod_hi || psc_src) nq++;
    end while (!div_pulse);
  endtask

  // Load, check the period in progress, skip the transition period, check the new one.
  task automatic reconf(input string tag, input bit b, input bit s, input int w,
                        output int npsc, output int n17, output int nq);
    int cyc, n;
    run_period(1'b1, 1'b0, b, s, w, 0, cyc, npsc, n17, nq);
    check("R9 period in progress", cyc, cur_n * cur_g);
    n = exp_n(b, s, w);
    cur_n = n;
    cur_g = b ? HG : LG;
    run_period(1'b0, 1'b0, b, s, w, 0, cyc, npsc, n17, nq);
    run_period(1'b0, 1'b0, b, s, w, 0, cyc, npsc, n17, nq);
    check(tag, cyc, cur_n * cur_g);
  endtask

  initial begin
    int cyc, np, n17, nq;
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc, np, n17, nq;
    rst = 1'b1; load = 1'b0; band_sel = 1'b0; swallow_sel = 1'b0; div_word = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 div_pulse", int'(div_pulse), 0);
    check("R1 mod_hi", int'(mod_hi), 0);
    check("R1 psc_src", int'(psc_src), 0);
    check("R1 range_err", int'(range_err), 0);
    wait_pulse();
    run_period(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, cyc, np, n17, nq);
    check("R1 default divide-by-4", cyc, 4 * LG);

    // Direct sweep over the low end of the range.
    for (int n = 4; n <= 40; n++) begin
      reconf("R2 direct period", 1'b0, 1'b0, n, np, n17, nq);
      check("R6 prescaler quiet in direct", nq, 0);
    end
    reconf("R2 direct 4095", 1'b0, 1'b0, 4095, np, n17, nq);
    reconf("R2 upper bits ignored", 1'b0, 1'b0, 16'hF00A, np, n17, nq);
    check("R6 prescaler quiet in direct", nq, 0);
    check("R8 no flag after legal loads", int'(range_err), 0);

    // Swallow sweep on the low band across every swallow count.
    for (int a = 0; a < 16; a++) begin
      reconf("R3 swallow period", 1'b0, 1'b1, 272 + a, np, n17, nq);
      check("R5 prescaler cycles", np, (272 + a) >> 4);
      check("R5 divide-by-17 cycles", n17, a);
    end
    reconf("R3 swallow 1000", 1'b0, 1'b1, 1000, np, n17, nq);
    check("R5 prescaler cycles", np, 62);
    check("R5 divide-by-17 cycles", n17, 8);
    reconf("R3 swallow 2063", 1'b0, 1'b1, 2063, np, n17, nq);
    check("R5 divide-by-17 cycles", n17, 15);

    // High band: swallow regardless of the swallow bit.
    reconf("R4 high band sw=0", 1'b1, 1'b0, 300, np, n17, nq);
    check("R4 prescaler cycles", np, 300 >> 4);
    check("R4 divide-by-17 cycles", n17, 300 & 15);
    reconf("R4 high band sw=1", 1'b1, 1'b1, 530, np, n17, nq);
    check("R8 no flag after legal loads", int'(range_err), 0);

    // Clamping.
    reconf("R7 direct clamp to 4", 1'b0, 1'b0, 16'hF002, np, n17, nq);
    check("R7 flag set", int'(range_err), 1);
    reconf("R7 swallow clamp to 272", 1'b0, 1'b1, 100, np, n17, nq);
    reconf("R8 legal load after error", 1'b0, 1'b0, 12, np, n17, nq);
    check("R8 flag sticky", int'(range_err), 1);

    // Two loads in one divide cycle: the later one applies.
    run_period(1'b1, 1'b1, 1'b0, 1'b0, 20, 7, cyc, np, n17, nq);
    check("R9 period in progress", cyc, cur_n * cur_g);
    cur_n = 7;
    run_period(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, cyc, np, n17, nq);
    check("R11 last load wins", cyc, 7 * LG);

    check("R10 single-cycle pulses", dbl, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule